// File: doc/BRIEF.md
# Square Wave Generator with Phase Tags

This block turns a sample-rate tick into a square wave and labels every sample tick with its position inside the wave period. A cycle counter moves forward by one on each tick of the sample clock. While the count is below a programmed high-length the output is high, and after that it is low. When the count would reach a programmed period length, it returns to zero. On every tick the block also presents the count that tick used, together with a one-clock valid strobe. Capture logic that stores converter samples can save this tag with each sample, so each stored sample records its phase in the wave.

The host writes the high-length and period-length settings into staging registers. These values only become the working settings at a period boundary, or while the block is disabled. A rewrite can therefore never cut a pulse short or stretch a period already in progress. Settings that would be out of range are clamped. When the enable input is low, the block rests with its counter at zero and its output low.

Top module: `sqw_phase_gen`

## Requirements
- R1: On each clock where `tick` and `en` are both high, the count advances by exactly one (or wraps, see R3). Between ticks the count, `wave_out` and `tag_count` keep their values.
- R2: `wave_out` is registered and updates one clock after an enabled tick. It is 1 when the count used by that tick is strictly less than the working high-length, and 0 when the count is equal to or greater than it. The high phase therefore lasts exactly high-length ticks.
- R3: When count+1 would reach the working period length, the next count is 0. The counter never holds a value of period length or more, and one output period lasts period-length ticks.
- R4: One clock after each enabled tick, `tag_valid` is 1 for exactly one clock and `tag_count` equals the count that tick used. `tag_valid` is 0 on every other clock.
- R5: A clock with `cfg_wr` high copies `cfg_half` and `cfg_full` into the staging registers. The working settings take the staged values only on the tick that wraps the counter to zero, or on a clock where `en` is low. A write made in the middle of a period does not change the rest of that period.
- R6: A period length of 0 is treated as 1. The counter then stays at 0 on every tick, and the output is high on every tick when the high-length is nonzero.
- R7: When the high-length is equal to or greater than the effective period length, `wave_out` is 1 after every enabled tick.
- R8: While `en` is low, the count is 0, `wave_out` is 0 and `tag_valid` is 0. The first tick after enabling uses count 0 and the latest staged settings.
- R9: After reset, `wave_out`, `tag_valid` and `tag_count` are 0, and the staged and working settings are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the counter at zero and the output low |
| tick | input | 1 | One-clock sample-rate tick |
| cfg_wr | input | 1 | Host write strobe for the staging registers |
| cfg_half | input | 16 | High-length setting, in ticks |
| cfg_full | input | 16 | Period-length setting, in ticks |
| wave_out | output | 1 | Registered square wave |
| tag_valid | output | 1 | One-clock strobe after each enabled tick |
| tag_count | output | 16 | Count used by the latest enabled tick |

## Verification
The assertions take for granted that `tick` is a single-clock pulse, and that `en` and `cfg_wr` are plain synchronous levels with no further meaning. They place no constraint on how often ticks arrive. The stimulus always spaces ticks several clocks apart, so the hold-between-ticks behaviour is observable. It never raises `cfg_wr` on the same clock as a wrap or a disable. This keeps every staged value clearly before or after the boundary that loads it. The sweep covers every high-length from 0 to 7 against every period length from 0 to 6. It also includes mid-period rewrites, so the clamp cases and the exact-equality edge are all reached.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  localparam int SQW_CW = 16;
  localparam int SQW_SW = SQW_CW + 1;

  typedef logic [SQW_CW-1:0] sqw_cnt_t;

  typedef struct packed {
    sqw_cnt_t half;
    sqw_cnt_t full;
  } sqw_cfg_t;

  // period length after clamping a zero value up to one
  function automatic sqw_cnt_t sqw_eff_full(sqw_cnt_t f);
    return (f == '0) ? sqw_cnt_t'(1) : f;
  endfunction

  // true when the step after count c would reach the period length
  function automatic logic sqw_wraps(sqw_cnt_t c, sqw_cnt_t f);
    logic [SQW_SW-1:0] sum;
    sum = {1'b0, c} + SQW_SW'(1);
    return sum >= {1'b0, sqw_eff_full(f)};
  endfunction

  function automatic sqw_cnt_t sqw_next(sqw_cnt_t c, sqw_cnt_t f);
    return sqw_wraps(c, f) ? '0 : c + sqw_cnt_t'(1);
  endfunction

  // output level for a count against a high-length
  function automatic logic sqw_level(sqw_cnt_t c, sqw_cnt_t h);
    return c < h;
  endfunction

endpackage

// File: rtl/sqw_shadow.sv
module sqw_shadow
  import sqw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     cfg_wr,
  input  sqw_cfg_t cfg_in,
  input  logic     wrap_evt,
  output sqw_cfg_t act_cfg
);

  sqw_cfg_t shd_q;
  sqw_cfg_t act_q;
  logic     load_evt;

  assign load_evt = wrap_evt || !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
    end else if (cfg_wr) begin
      shd_q <= cfg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (load_evt) begin
      act_q <= shd_q;
    end
  end

  assign act_cfg = act_q;

  a_r5_hold_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_evt) |=> $stable(act_q));

  a_r5_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt || !en) |=> (act_q == $past(shd_q)));

  a_r5_write_captured: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (shd_q == $past(cfg_in)));

endmodule

// File: rtl/sqw_counter.sv
module sqw_counter
  import sqw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick_en,
  input  sqw_cnt_t act_full,
  output sqw_cnt_t cnt,
  output logic     wrap_evt
);

  sqw_cnt_t cnt_q;
  sqw_cnt_t cnt_d;

  assign wrap_evt = tick_en && sqw_wraps(cnt_q, act_full);

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = sqw_next(cnt_q, act_full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wrap_evt) |=> (cnt_q == $past(cnt_q) + sqw_cnt_t'(1)));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick_en) |=> $stable(cnt_q));

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == '0));

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < sqw_eff_full(act_full));

  a_r8_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/sqw_output.sv
module sqw_output
  import sqw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick_en,
  input  sqw_cnt_t cnt,
  input  sqw_cnt_t act_half,
  input  sqw_cnt_t act_full,
  output logic     wave,
  output logic     tag_valid,
  output sqw_cnt_t tag_count
);

  logic     wave_q;
  logic     tv_q;
  sqw_cnt_t tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
      tv_q   <= 1'b0;
      tag_q  <= '0;
    end else if (!en) begin
      wave_q <= 1'b0;
      tv_q   <= 1'b0;
    end else begin
      tv_q <= tick_en;
      if (tick_en) begin
        wave_q <= sqw_level(cnt, act_half);
        tag_q  <= cnt;
      end
    end
  end

  assign wave      = wave_q;
  assign tag_valid = tv_q;
  assign tag_count = tag_q;

  a_r2_level: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (wave_q == ($past(cnt) < $past(act_half))));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick_en) |=> ($stable(wave_q) && $stable(tag_q)));

  a_r4_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> tv_q);

  a_r4_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !tv_q);

  a_r4_tag_value: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (tag_q == $past(cnt)));

  a_r7_always_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (act_half >= sqw_eff_full(act_full))) |=> wave_q);

  a_r8_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!wave_q && !tv_q));

endmodule

// File: rtl/sqw_phase_gen.sv
module sqw_phase_gen
  import sqw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic [SQW_CW-1:0] cfg_half,
  input  logic [SQW_CW-1:0] cfg_full,
  output logic              wave_out,
  output logic              tag_valid,
  output logic [SQW_CW-1:0] tag_count
);

  logic     tick_en;
  logic     wrap_evt;
  sqw_cfg_t cfg_in;
  sqw_cfg_t act_cfg;
  sqw_cnt_t cnt;

  assign tick_en = tick && en;
  assign cfg_in  = '{half: cfg_half, full: cfg_full};

  sqw_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cfg_wr   (cfg_wr),
    .cfg_in   (cfg_in),
    .wrap_evt (wrap_evt),
    .act_cfg  (act_cfg)
  );

  sqw_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tick_en  (tick_en),
    .act_full (act_cfg.full),
    .cnt      (cnt),
    .wrap_evt (wrap_evt)
  );

  sqw_output u_output (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tick_en   (tick_en),
    .cnt       (cnt),
    .act_half  (act_cfg.half),
    .act_full  (act_cfg.full),
    .wave      (wave_out),
    .tag_valid (tag_valid),
    .tag_count (tag_count)
  );

  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_valid) |-> $past(tick_en));

endmodule

// File: tb/test_sqw_phase_gen.sv
module test_sqw_phase_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_half = '0;
  logic [15:0] cfg_full = '0;
  logic        wave_out;
  logic        tag_valid;
  logic [15:0] tag_count;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // bench model state
  int m_cnt = 0, m_half = 0, m_full = 0, s_half = 0, s_full = 0;

  always #2 clk = ~clk;

  sqw_phase_gen i_sqw_phase_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cfg_wr(cfg_wr),
    .cfg_half(cfg_half), .cfg_full(cfg_full),
    .wave_out(wave_out), .tag_valid(tag_valid), .tag_count(tag_count)
  );

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic host_write(int h, int f);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_half = 16'(h); cfg_full = 16'(f);
    @(negedge clk);
    cfg_wr = 1'b0;
    s_half = h; s_full = f;
  endtask

  // disable for a few clocks (R8), then enable; working settings follow staging
  task automatic restart();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 wave low while off", int'(wave_out), 0);
    check("R8 strobe low while off", int'(tag_valid), 0);
    m_cnt = 0; m_half = s_half; m_full = s_full;
    en = 1'b1;
  endtask

  task automatic do_tick(bit check_hold);
    int eff, exp_wave, exp_tag;
    exp_tag  = m_cnt;
    exp_wave = (m_cnt < m_half) ? 1 : 0;
    eff = (m_full == 0) ? 1 : m_full;
    m_cnt = (m_cnt + 1 >= eff) ? 0 : m_cnt + 1;
    if (m_cnt == 0) begin
      m_half = s_half; m_full = s_full;
    end
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R4 strobe after tick", int'(tag_valid), 1);
    check("R1 R3 tag count", int'(tag_count), exp_tag);
    check("R2 R6 R7 wave level", int'(wave_out), exp_wave);
    @(negedge clk);
    if (check_hold) begin
      check("R4 strobe one clock", int'(tag_valid), 0);
      check("R1 hold wave between ticks", int'(wave_out), exp_wave);
      check("R1 hold tag between ticks", int'(tag_count), exp_tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 wave after reset", int'(wave_out), 0);
    check("R9 strobe after reset", int'(tag_valid), 0);
    check("R9 tag after reset", int'(tag_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R6 R7: sweep every half 0..7 against every full 0..6
    for (int f = 0; f <= 6; f++) begin
      for (int h = 0; h <= 7; h++) begin
        host_write(h, f);
        restart();
        for (int t = 0; t < 2 * ((f == 0) ? 1 : f) + 1; t++) do_tick(t < 2);
      end
    end

    // R5: rewrite mid-period; old settings finish the period, new take over at wrap
    host_write(2, 5);
    restart();
    do_tick(1'b1);
    do_tick(1'b1);
    host_write(1, 3);
    for (int t = 0; t < 10; t++) do_tick(1'b0);

    // R5: rewrite to period 0 mid-period, then back (R6)
    host_write(4, 0);
    for (int t = 0; t < 6; t++) do_tick(1'b0);
    host_write(3, 6);
    for (int t = 0; t < 8; t++) do_tick(1'b0);

    // R8: restart mid-period returns to count 0 with latest staging
    host_write(5, 7);
    do_tick(1'b0);
    restart();
    for (int t = 0; t < 9; t++) do_tick(1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule